// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the bus-master control state for two disk-controller channels, primary and secondary, behind a byte-addressed register port. Each channel owns a command byte, a status byte and a 32-bit descriptor pointer. Software starts a transfer by setting the channel's run bit. The block then marks the channel busy and sends a one-cycle start pulse to an external DMA engine, together with the descriptor pointer. Clearing the run bit sends an abort pulse instead.

When the engine finishes, it pulses a done input. In that one cycle the block stops the channel, drops the busy flag and raises the channel's interrupt flag. That flag drives a per-channel interrupt line until software clears it by writing one. The error flag uses the same write-one-to-clear rule. A global bus-master enable input gates every register write. Reads return register bytes little-endian, at the requested size, with no added latency.

Top module: `busmaster_dma_regs`

## Requirements
- R1: Channel c (0 primary, 1 secondary) occupies byte offsets 8c to 8c+7: command at 8c+0, status at 8c+2, pointer at 8c+4..8c+7 (least significant byte first). Bytes 8c+1 and 8c+3 read as zero, and writes to them are ignored.
- R2: After a synchronous reset every status byte reads 0x60, and every command byte and pointer reads zero. irq, start_pulse and abort_pulse are low.
- R3: A command write takes effect only with size byte (req_size 0). A command write of any other size changes nothing.
- R4: The command direction bit is bit 3. While status busy (bit 0) is set, a command write keeps the old direction bit. When busy is clear, the written direction bit is stored.
- R5: The command run bit is bit 0. A command write that changes run from 0 to 1 sets status busy. In the next cycle start_pulse[c] is high for exactly one cycle, and start_ptr[32c+31:32c] holds the channel's pointer.
- R6: A command write that changes run from 1 to 0 clears status busy and raises abort_pulse[c] for one cycle, starting in the next cycle.
- R7: Status writes are byte-size only. Busy (bit 0) is read-only. Error (bit 1) and interrupt (bit 2) are cleared by writing 1 while they are set. Writing 0 to them, or writing 1 while they are clear, leaves them unchanged. Bits 7..3 take the written value.
- R8: A pointer write takes effect only with size word (req_size 2) at offset 8c+4. The stored value has bits 1..0 forced to zero.
- R9: A done[c] pulse clears run and busy and sets the interrupt bit. irq[c] is high whenever the interrupt bit is set.
- R10: While bm_en is low, every register write is ignored. done still takes effect.
- R11: A done[c] pulse in the same cycle as a write to that channel wins over the write: run and busy end at 0 and interrupt ends at 1, and no start or abort pulse follows. The other written bits still take effect.
- R12: rd_data returns bytes req_addr, req_addr+1, ... little-endian. req_size 0 returns one byte, 1 returns two bytes, 2 (and 3) returns four bytes. Bytes past offset 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bm_en | input | 1 | Bus-master enable; writes are ignored while low |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 4 | Byte offset into the register space |
| req_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Read data for the current address and size |
| done | input | 2 | Per-channel completion pulse from the DMA engine |
| start_pulse | output | 2 | Per-channel one-cycle start request |
| abort_pulse | output | 2 | Per-channel one-cycle abort request |
| start_ptr | output | 64 | Per-channel descriptor pointer, channel c at bits 32c+31:32c |
| irq | output | 2 | Per-channel interrupt line |

## Verification
Completion from the engine and a register write can land on the same channel in the same cycle. This is the interaction with the most risk. The bench provokes it by asserting done on the same clock edge as a stop write, a start write and a write-one-to-clear of the interrupt bit. It then judges that no start or abort pulse appears, that run and busy read zero, and that the interrupt bit is still set.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int CHAN_STRIDE = 8;
    localparam int OFF_CMD     = 0;
    localparam int OFF_STS     = 2;
    localparam int OFF_PTR     = 4;
    localparam int PTR_W       = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic [3:0] spare_hi;
        logic       dir;
        logic [1:0] spare_lo;
        logic       run;
    } cmd_reg_t;

    typedef struct packed {
        logic [4:0] plain;
        logic       intr;
        logic       err;
        logic       act;
    } sts_reg_t;

    localparam cmd_reg_t CMD_RESET = '0;
    localparam sts_reg_t STS_RESET = '{plain: 5'b01100, intr: 1'b0, err: 1'b0, act: 1'b0};

    function automatic logic [31:0] size_mask(input xfer_size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00ff;
            SZ_HALF: return 32'h0000_ffff;
            default: return 32'hffff_ffff;
        endcase
    endfunction

    function automatic logic clear_on_one(input logic cur, input logic wr);
        return cur & ~wr;
    endfunction

endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cmd,
    input  logic             wr_sts,
    input  logic             wr_ptr,
    input  logic [31:0]      wdata,
    input  logic             done,
    output cmd_reg_t         cmd_q,
    output sts_reg_t         sts_q,
    output logic [PTR_W-1:0] ptr_q,
    output logic             start_p,
    output logic             abort_p
);

    cmd_reg_t         cmd_n;
    sts_reg_t         sts_n;
    logic [PTR_W-1:0] ptr_n;
    logic             start_n;
    logic             abort_n;

    always_comb begin
        cmd_reg_t wc;
        sts_reg_t ws;
        cmd_n   = cmd_q;
        sts_n   = sts_q;
        ptr_n   = ptr_q;
        start_n = 1'b0;
        abort_n = 1'b0;
        wc      = cmd_reg_t'(wdata[7:0]);
        ws      = sts_reg_t'(wdata[7:0]);

        if (wr_cmd) begin
            if (sts_q.act) begin
                wc.dir = cmd_q.dir;
            end
            if (wc.run && !cmd_q.run) begin
                sts_n.act = 1'b1;
                start_n   = 1'b1;
            end else if (!wc.run && cmd_q.run) begin
                sts_n.act = 1'b0;
                abort_n   = 1'b1;
            end
            cmd_n = wc;
        end

        if (wr_sts) begin
            sts_n.plain = ws.plain;
            sts_n.intr  = clear_on_one(sts_q.intr, ws.intr);
            sts_n.err   = clear_on_one(sts_q.err, ws.err);
        end

        if (wr_ptr) begin
            ptr_n = {wdata[PTR_W-1:2], 2'b00};
        end

        if (done) begin
            cmd_n.run  = 1'b0;
            sts_n.act  = 1'b0;
            sts_n.intr = 1'b1;
            start_n    = 1'b0;
            abort_n    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_RESET;
            sts_q   <= STS_RESET;
            ptr_q   <= '0;
            start_p <= 1'b0;
            abort_p <= 1'b0;
        end else begin
            cmd_q   <= cmd_n;
            sts_q   <= sts_n;
            ptr_q   <= ptr_n;
            start_p <= start_n;
            abort_p <= abort_n;
        end
    end

endmodule

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 4
) (
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     bm_en,
    input  logic [1:0]               req_size,
    input  logic [AW-1:0]            req_addr,
    input  cmd_reg_t [NCH-1:0]       cmd_i,
    input  sts_reg_t [NCH-1:0]       sts_i,
    input  logic [NCH*PTR_W-1:0]     ptr_i,
    output logic [NCH-1:0]           wr_cmd,
    output logic [NCH-1:0]           wr_sts,
    output logic [NCH-1:0]           wr_ptr,
    output logic [31:0]              rd_data
);

    localparam int NBYTES = NCH * CHAN_STRIDE;

    xfer_size_e sz;
    logic       wr_ok;
    logic [7:0] img [NBYTES];

    assign sz    = xfer_size_e'(req_size);
    assign wr_ok = req_valid && req_write && bm_en;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int BASE = c * CHAN_STRIDE;

        assign img[BASE + 0] = cmd_i[c];
        assign img[BASE + 1] = 8'h00;
        assign img[BASE + 2] = sts_i[c];
        assign img[BASE + 3] = 8'h00;
        for (genvar b = 0; b < 4; b++) begin : g_ptr_byte
            assign img[BASE + OFF_PTR + b] = ptr_i[c*PTR_W + 8*b +: 8];
        end

        assign wr_cmd[c] = wr_ok && (int'(req_addr) == BASE + OFF_CMD) && (sz == SZ_BYTE);
        assign wr_sts[c] = wr_ok && (int'(req_addr) == BASE + OFF_STS) && (sz == SZ_BYTE);
        assign wr_ptr[c] = wr_ok && (int'(req_addr) == BASE + OFF_PTR) && (sz == SZ_WORD);
    end

    always_comb begin
        logic [31:0] raw;
        raw = '0;
        for (int k = 0; k < 4; k++) begin
            logic [AW:0] idx;
            idx = {1'b0, req_addr} + (AW+1)'(k);
            if (int'(idx) < NBYTES) begin
                raw[8*k +: 8] = img[idx[AW-1:0]];
            end
        end
        rd_data = raw & size_mask(sz);
    end

endmodule

// File: rtl/busmaster_dma_regs.sv
module busmaster_dma_regs
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = $clog2(NCH * CHAN_STRIDE)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bm_en,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [AW-1:0]        req_addr,
    input  logic [31:0]          req_wdata,
    output logic [31:0]          rd_data,
    input  logic [NCH-1:0]       done,
    output logic [NCH-1:0]       start_pulse,
    output logic [NCH-1:0]       abort_pulse,
    output logic [NCH*PTR_W-1:0] start_ptr,
    output logic [NCH-1:0]       irq
);

    cmd_reg_t [NCH-1:0]   cmd_q;
    sts_reg_t [NCH-1:0]   sts_q;
    logic [NCH*PTR_W-1:0] ptr_q;
    logic [NCH-1:0]       wr_cmd;
    logic [NCH-1:0]       wr_sts;
    logic [NCH-1:0]       wr_ptr;

    bmdma_decode #(.NCH(NCH), .AW(AW)) decode_i (
        .req_valid (req_valid),
        .req_write (req_write),
        .bm_en     (bm_en),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .cmd_i     (cmd_q),
        .sts_i     (sts_q),
        .ptr_i     (ptr_q),
        .wr_cmd    (wr_cmd),
        .wr_sts    (wr_sts),
        .wr_ptr    (wr_ptr),
        .rd_data   (rd_data)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bmdma_chan chan_i (
            .clk     (clk),
            .rst     (rst),
            .wr_cmd  (wr_cmd[c]),
            .wr_sts  (wr_sts[c]),
            .wr_ptr  (wr_ptr[c]),
            .wdata   (req_wdata),
            .done    (done[c]),
            .cmd_q   (cmd_q[c]),
            .sts_q   (sts_q[c]),
            .ptr_q   (ptr_q[c*PTR_W +: PTR_W]),
            .start_p (start_pulse[c]),
            .abort_p (abort_pulse[c])
        );
        assign irq[c] = sts_q[c].intr;
    end

    assign start_ptr = ptr_q;

endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk
    import bmdma_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bm_en,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [NCH-1:0]       done,
    input logic [NCH-1:0]       start_pulse,
    input logic [NCH-1:0]       abort_pulse,
    input logic [NCH-1:0]       irq,
    input cmd_reg_t [NCH-1:0]   cmd_q,
    input sts_reg_t [NCH-1:0]   sts_q,
    input logic [NCH*PTR_W-1:0] ptr_q
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R4: the direction bit does not move while the channel is busy
        assert_dir_locked_R4: assert property (@(posedge clk) disable iff (rst)
            sts_q[c].act |=> cmd_q[c].dir == $past(cmd_q[c].dir));

        // R5: a start pulse coincides with a running, busy channel and lasts one cycle
        assert_start_busy_R5: assert property (@(posedge clk) disable iff (rst)
            start_pulse[c] |-> (sts_q[c].act && cmd_q[c].run));
        assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
            start_pulse[c] |=> !start_pulse[c]);

        // R6: an abort pulse coincides with busy cleared
        assert_abort_idle_R6: assert property (@(posedge clk) disable iff (rst)
            abort_pulse[c] |-> !sts_q[c].act);

        // R7: a set interrupt stays set unless a write or a reset intervenes
        assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
            (irq[c] && !(req_valid && req_write)) |=> irq[c]);

        // R9: completion stops the channel and raises the interrupt
        assert_done_effect_R9: assert property (@(posedge clk) disable iff (rst)
            done[c] |=> (!cmd_q[c].run && !sts_q[c].act && irq[c]));

        // R10: nothing changes while bus mastering is disabled and no completion arrives
        assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (rst)
            (!bm_en && !done[c]) |=> ($stable(cmd_q[c]) && $stable(sts_q[c])
                                      && $stable(ptr_q[c*PTR_W +: PTR_W])));

        // R11: completion suppresses any pulse from a same-cycle write
        assert_done_no_pulse_R11: assert property (@(posedge clk) disable iff (rst)
            done[c] |=> (!start_pulse[c] && !abort_pulse[c]));
    end

endmodule

bind busmaster_dma_regs bmdma_chk #(.NCH(NCH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bm_en       (bm_en),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .done        (done),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse),
    .irq         (irq),
    .cmd_q       (cmd_q),
    .sts_q       (sts_q),
    .ptr_q       (ptr_q)
);

// File: tb/busmaster_dma_regs_tb_top.sv
`timescale 1ns/1ps
module busmaster_dma_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bm_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [3:0]  req_addr = 4'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [1:0]  done = 2'b00;
    logic [31:0] rd_data;
    logic [1:0]  start_pulse;
    logic [1:0]  abort_pulse;
    logic [63:0] start_ptr;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    busmaster_dma_regs dut_i (
        .clk         (clk),
        .rst         (rst),
        .bm_en       (bm_en),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_size    (req_size),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rd_data     (rd_data),
        .done        (done),
        .start_pulse (start_pulse),
        .abort_pulse (abort_pulse),
        .start_ptr   (start_ptr),
        .irq         (irq)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  wsz;
        logic [3:0]  waddr;
        logic [31:0] wdata;
        logic [1:0]  rsz;
        logic [3:0]  raddr;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd2, 4'd4,  32'h1234_5677, 2'd2, 4'd4,  32'h1234_5674, 4'd8},  // R8 low bits forced
        '{1'b1, 2'd1, 4'd4,  32'h0000_ffff, 2'd2, 4'd4,  32'h1234_5674, 4'd8},  // R8 half size ignored
        '{1'b1, 2'd0, 4'd0,  32'h0000_0008, 2'd0, 4'd0,  32'h0000_0008, 4'd3},  // R3 byte write
        '{1'b1, 2'd1, 4'd0,  32'h0000_0000, 2'd0, 4'd0,  32'h0000_0008, 4'd3},  // R3 half ignored
        '{1'b1, 2'd0, 4'd0,  32'h0000_0009, 2'd0, 4'd2,  32'h0000_0061, 4'd5},  // R5 busy set
        '{1'b1, 2'd0, 4'd0,  32'h0000_0001, 2'd0, 4'd0,  32'h0000_0009, 4'd4},  // R4 dir locked
        '{1'b1, 2'd0, 4'd0,  32'h0000_0008, 2'd0, 4'd2,  32'h0000_0060, 4'd6},  // R6 busy cleared
        '{1'b1, 2'd0, 4'd0,  32'h0000_0000, 2'd0, 4'd0,  32'h0000_0000, 4'd4},  // R4 dir free when idle
        '{1'b1, 2'd0, 4'd2,  32'h0000_0087, 2'd0, 4'd2,  32'h0000_0080, 4'd7},  // R7 plain bits, no set
        '{1'b1, 2'd0, 4'd2,  32'h0000_0060, 2'd0, 4'd2,  32'h0000_0060, 4'd7},  // R7 restore
        '{1'b1, 2'd2, 4'd12, 32'hdead_beef, 2'd2, 4'd12, 32'hdead_beec, 4'd1},  // R1 secondary pointer
        '{1'b0, 2'd0, 4'd0,  32'h0000_0000, 2'd1, 4'd2,  32'h0000_0060, 4'd12}, // R12 halfword
        '{1'b0, 2'd0, 4'd0,  32'h0000_0000, 2'd2, 4'd8,  32'h0060_0000, 4'd1},  // R1 secondary layout
        '{1'b0, 2'd0, 4'd0,  32'h0000_0000, 2'd2, 4'd14, 32'h0000_dead, 4'd12}, // R12 past the end
        '{1'b1, 2'd0, 4'd1,  32'h0000_00ff, 2'd2, 4'd0,  32'h0060_0000, 4'd1}   // R1 reserved byte
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic we, input logic [1:0] sz, input logic [3:0] a,
                      input logic [31:0] d, input logic [1:0] dn);
        @(negedge clk);
        req_valid = we;
        req_write = we;
        req_size  = sz;
        req_addr  = a;
        req_wdata = d;
        done      = dn;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_write = 1'b0;
        done      = 2'b00;
    endtask

    task automatic rd(input logic [1:0] sz, input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_size  = sz;
        req_addr  = a;
        #1;
        v = rd_data;
        req_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R2 reset state
        rd(2'd2, 4'd0, v);  chk("R2 ch0 cmd/sts", v, 32'h0060_0000);
        rd(2'd2, 4'd8, v);  chk("R2 ch1 cmd/sts", v, 32'h0060_0000);
        rd(2'd2, 4'd4, v);  chk("R2 ch0 ptr", v, 32'h0);
        rd(2'd2, 4'd12, v); chk("R2 ch1 ptr", v, 32'h0);
        chk("R2 outputs", {irq, start_pulse, abort_pulse}, 6'b0);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].we) op(1'b1, VECS[i].wsz, VECS[i].waddr, VECS[i].wdata, 2'b00);
            rd(VECS[i].rsz, VECS[i].raddr, v);
            chk($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
        end

        // R5 start pulse on secondary, pointer presented
        op(1'b1, 2'd0, 4'd8, 32'h01, 2'b00);
        chk("R5 start pulse", {start_pulse, abort_pulse}, 4'b1000);
        chk("R5 start ptr", start_ptr[63:32], 32'hdead_beec);
        @(posedge clk); #1;
        chk("R5 pulse one cycle", start_pulse, 2'b00);
        rd(2'd0, 4'd10, v); chk("R5 ch1 busy", v, 32'h61);

        // R6 abort pulse
        op(1'b1, 2'd0, 4'd8, 32'h00, 2'b00);
        chk("R6 abort pulse", {start_pulse, abort_pulse}, 4'b0010);
        rd(2'd0, 4'd10, v); chk("R6 ch1 idle", v, 32'h60);

        // R9 completion and R7 clear rules
        op(1'b1, 2'd0, 4'd0, 32'h01, 2'b00);
        op(1'b0, 2'd0, 4'd0, 32'h00, 2'b01);
        chk("R9 irq set", irq, 2'b01);
        rd(2'd0, 4'd2, v); chk("R9 ch0 status", v, 32'h64);
        rd(2'd0, 4'd0, v); chk("R9 ch0 run cleared", v, 32'h00);
        op(1'b1, 2'd0, 4'd2, 32'h60, 2'b00);
        rd(2'd0, 4'd2, v); chk("R7 write zero keeps intr", v, 32'h64);
        op(1'b1, 2'd0, 4'd2, 32'h64, 2'b00);
        rd(2'd0, 4'd2, v); chk("R7 write one clears intr", v, 32'h60);
        chk("R9 irq low", irq, 2'b00);

        // R10 writes ignored while disabled, done still acts
        bm_en = 1'b0;
        op(1'b1, 2'd0, 4'd8, 32'h01, 2'b00);
        chk("R10 no start", start_pulse, 2'b00);
        rd(2'd0, 4'd8, v); chk("R10 ch1 cmd kept", v, 32'h00);
        op(1'b1, 2'd2, 4'd4, 32'h0, 2'b00);
        rd(2'd2, 4'd4, v); chk("R10 ch0 ptr kept", v, 32'h1234_5674);
        op(1'b0, 2'd0, 4'd0, 32'h0, 2'b10);
        chk("R10 done still acts", irq, 2'b10);
        bm_en = 1'b1;
        op(1'b1, 2'd0, 4'd10, 32'h64, 2'b00);
        chk("R7 ch1 clear", irq, 2'b00);

        // R11 completion in the same cycle as writes
        op(1'b1, 2'd0, 4'd0, 32'h01, 2'b00);
        op(1'b1, 2'd0, 4'd0, 32'h00, 2'b01);
        chk("R11 stop+done no abort", {start_pulse, abort_pulse}, 4'b0000);
        rd(2'd0, 4'd0, v); chk("R11 stop+done cmd", v, 32'h00);
        rd(2'd0, 4'd2, v); chk("R11 stop+done status", v, 32'h64);
        op(1'b1, 2'd0, 4'd2, 32'h64, 2'b01);
        rd(2'd0, 4'd2, v); chk("R11 clear+done intr stays", v, 32'h64);
        op(1'b1, 2'd0, 4'd2, 32'h64, 2'b00);
        op(1'b1, 2'd0, 4'd0, 32'h09, 2'b01);
        chk("R11 start+done no start", {start_pulse, abort_pulse}, 4'b0000);
        rd(2'd0, 4'd0, v); chk("R11 start+done cmd", v, 32'h08);
        rd(2'd0, 4'd2, v); chk("R11 start+done status", v, 32'h64);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule